// File: doc/BRIEF.md
# Overlapped Seven-Step Register-Operation Sequencer

This block is a small execution core for register-to-register instructions. It gives every step of an instruction its own clock cycle and its own register stage, so each cycle holds very little logic. There are seven steps. The core fetches a 16-bit word from an internal synchronous instruction RAM and decodes it. It reads two entries of an eight-entry, 32-bit register file. An operand multiplexer then chooses the operands. Three operation units (add/subtract, bitwise logic and move) work in parallel. A result multiplexer picks the output of one unit, and the result is written back to the register file.

Consecutive instructions partly overlap. An instruction's fetch, decode and register read run in the same three cycles as the previous instruction's execute, result selection and writeback. The register read of one instruction shares a cycle with the writeback of the one before it. Two forwarding inputs on the operand multiplexer therefore carry the value being written back. With these overlaps, one instruction issues every four cycles, and each instruction still takes seven cycles from fetch to writeback.

The program is loaded through a write port on the instruction RAM while reset is held. Execution starts at address 0 in the first cycle after reset is released.

Top module: `rrseq_core`

## Requirements
- R1: While reset is high (synchronous, active high), register k reads back as 0x11111111 multiplied by (k+1), for example register 7 reads 0x88888888. retire_o is low in the cycle after every reset cycle and fetch_o is low during reset. In the first cycle after reset is released, fetch_o is high and fetch_pc_o is 0.
- R2: The instruction word holds the opcode in bits [15:12], the destination index in bits [11:9] and the source index in bits [2:0]. Each instruction computes dest = dest op src. The opcodes are 0 add, 1 subtract (dest minus src), 2 AND, 3 OR, 4 XOR and 5 move (dest = src).
- R3: Bits [8:3] of the instruction word have no effect on the results.
- R4: Opcodes 6 to 15 take a normal four-cycle slot. They raise retire_o with retire_we_o low and leave every register unchanged.
- R5: fetch_o is high for one cycle in every four. fetch_pc_o rises by one at each fetch and wraps from 255 to 0.
- R6: An instruction fetched in cycle t raises retire_o in cycle t+6, and the written value shows on regs_o from cycle t+7. Successive retirements are four cycles apart.
- R7: If an instruction's destination or source index matches the destination of the instruction immediately before it, the instruction uses that earlier instruction's result and not the stale register file value.
- R8: While retire_o is high, retire_rd_o gives the destination index and retire_val_o gives the value being written.
- R9: Writing a word through the instruction RAM write port stores it at that address (256 words), and later fetches from that address read it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| imem_we_i | input | 1 | Instruction RAM write enable |
| imem_waddr_i | input | 8 | Instruction RAM write address |
| imem_wdata_i | input | 16 | Instruction word to write |
| fetch_o | output | 1 | High in the cycle an instruction word is fetched |
| fetch_pc_o | output | 8 | Address being fetched |
| retire_o | output | 1 | High in an instruction's writeback cycle |
| retire_we_o | output | 1 | The retiring instruction writes a register |
| retire_rd_o | output | 3 | Destination index of the retiring instruction |
| retire_val_o | output | 32 | Result of the retiring instruction |
| regs_o | output | 256 | All registers, register k in bits [32k+31:32k] |

## Verification
The assertions assume that reset is held for at least one clock edge before execution begins. They also assume that the instruction RAM is not written while the program runs, because a fetch racing a write is outside their model. The bench follows both assumptions: it writes all 256 words with reset high, releases reset one clock edge after the last write, and then drives only the clock until the run ends. Any opcode and any pair of register indices is legal, so the stimulus sweeps every combination of opcode and index pair, with random-looking values in bits [8:3]. A separate chained program makes each source index equal the previous destination, so that the source forwarding path is exercised.

// File: rtl/rrseq_pkg.sv
`timescale 1ns/1ps
package rrseq_pkg;

    localparam int OP_HI = 15;
    localparam int OP_LO = 12;
    localparam int RD_HI = 11;
    localparam int RD_LO = 9;
    localparam int RS_HI = 2;
    localparam int RS_LO = 0;

    typedef enum logic [2:0] {
        K_ADD = 3'd0,
        K_SUB = 3'd1,
        K_AND = 3'd2,
        K_OR  = 3'd3,
        K_XOR = 3'd4,
        K_MOV = 3'd5,
        K_NOP = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        U_ARITH = 2'd0,
        U_LOGIC = 2'd1,
        U_MOVE  = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        L_AND = 2'd0,
        L_OR  = 2'd1,
        L_XOR = 2'd2
    } lsel_e;

    function automatic kind_e decode_kind(input logic [3:0] op);
        case (op)
            4'd0:    return K_ADD;
            4'd1:    return K_SUB;
            4'd2:    return K_AND;
            4'd3:    return K_OR;
            4'd4:    return K_XOR;
            4'd5:    return K_MOV;
            default: return K_NOP;
        endcase
    endfunction

    function automatic unit_e unit_of(input kind_e k);
        case (k)
            K_ADD, K_SUB:        return U_ARITH;
            K_AND, K_OR, K_XOR:  return U_LOGIC;
            default:             return U_MOVE;
        endcase
    endfunction

    function automatic lsel_e lsel_of(input kind_e k);
        case (k)
            K_OR:    return L_OR;
            K_XOR:   return L_XOR;
            default: return L_AND;
        endcase
    endfunction

endpackage

// File: rtl/rrseq_imem.sv
`timescale 1ns/1ps
module rrseq_imem #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             re_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (re_i) begin
            rdata_q <= mem[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/rrseq_regfile.sv
`timescale 1ns/1ps
module rrseq_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 we_i,
    input  logic [RIDX-1:0]      widx_i,
    input  logic [XLEN-1:0]      wdata_i,
    input  logic [RIDX-1:0]      ridx_a_i,
    input  logic [RIDX-1:0]      ridx_b_i,
    output logic [XLEN-1:0]      rdata_a_o,
    output logic [XLEN-1:0]      rdata_b_o,
    output logic [NREG*XLEN-1:0] flat_o
);

    logic [NREG-1:0][XLEN-1:0] view;

    for (genvar k = 0; k < NREG; k++) begin : g_ent
        localparam logic [XLEN-1:0] SEED = {(XLEN/4){4'(k + 1)}};
        logic [XLEN-1:0] ent_d;
        logic [XLEN-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we_i && (widx_i == RIDX'(k))) begin
                ent_d = wdata_i;
            end
            if (rst_i) begin
                ent_d = SEED;
            end
        end

        always_ff @(posedge clk_i) begin
            ent_q <= ent_d;
        end

        assign view[k] = ent_q;
    end

    assign rdata_a_o = view[ridx_a_i];
    assign rdata_b_o = view[ridx_b_i];
    assign flat_o    = view;

endmodule

// File: rtl/rrseq_arith.sv
`timescale 1ns/1ps
module rrseq_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] y_o
);

    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        y_o   = a_i + b_eff + XLEN'(sub_i);
    end

endmodule

// File: rtl/rrseq_logic.sv
`timescale 1ns/1ps
module rrseq_logic
    import rrseq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  lsel_e           sel_i,
    output logic [XLEN-1:0] y_o
);

    always_comb begin
        case (sel_i)
            L_OR:    y_o = a_i | b_i;
            L_XOR:   y_o = a_i ^ b_i;
            default: y_o = a_i & b_i;
        endcase
    end

endmodule

// File: rtl/rrseq_core.sv
`timescale 1ns/1ps
module rrseq_core
    import rrseq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 8,
    parameter int DEPTH = 256,
    parameter int IW    = 16,
    localparam int RIDX = $clog2(NREG),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 imem_we_i,
    input  logic [AW-1:0]        imem_waddr_i,
    input  logic [IW-1:0]        imem_wdata_i,
    output logic                 fetch_o,
    output logic [AW-1:0]        fetch_pc_o,
    output logic                 retire_o,
    output logic                 retire_we_o,
    output logic [RIDX-1:0]      retire_rd_o,
    output logic [XLEN-1:0]      retire_val_o,
    output logic [NREG*XLEN-1:0] regs_o
);

    typedef struct packed {
        logic [1:0]      phase;
        logic [AW-1:0]   pc;
        // decode step
        logic            s2_v;
        // register read step
        logic            s3_v;
        kind_e           s3_kind;
        logic [RIDX-1:0] s3_rd;
        logic [RIDX-1:0] s3_rs;
        // operand select step
        logic            s4_v;
        kind_e           s4_kind;
        logic [RIDX-1:0] s4_rd;
        logic [XLEN-1:0] s4_rdv;
        logic [XLEN-1:0] s4_rsv;
        logic            s4_hit_rd;
        logic            s4_hit_rs;
        logic [XLEN-1:0] s4_fwd;
        // execute step
        logic            s5_v;
        kind_e           s5_kind;
        logic [RIDX-1:0] s5_rd;
        logic [XLEN-1:0] s5_a;
        logic [XLEN-1:0] s5_b;
        // result select step
        logic            s6_v;
        logic            s6_we;
        unit_e           s6_unit;
        logic [RIDX-1:0] s6_rd;
        logic [XLEN-1:0] s6_arith;
        logic [XLEN-1:0] s6_logic;
        logic [XLEN-1:0] s6_move;
        // writeback step
        logic            s7_v;
        logic            s7_we;
        logic [RIDX-1:0] s7_rd;
        logic [XLEN-1:0] s7_res;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic            fetch;
    logic [IW-1:0]   iword;
    logic [XLEN-1:0] rf_a;
    logic [XLEN-1:0] rf_b;
    logic [XLEN-1:0] arith_y;
    logic [XLEN-1:0] logic_y;
    logic            wb_we;

    assign fetch = (st_q.phase == 2'd0);
    assign wb_we = st_q.s7_v & st_q.s7_we;

    rrseq_imem #(
        .DEPTH (DEPTH),
        .WIDTH (IW)
    ) u_imem (
        .clk_i   (clk_i),
        .we_i    (imem_we_i),
        .waddr_i (imem_waddr_i),
        .wdata_i (imem_wdata_i),
        .re_i    (fetch),
        .raddr_i (st_q.pc),
        .rdata_o (iword)
    );

    rrseq_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (wb_we),
        .widx_i    (st_q.s7_rd),
        .wdata_i   (st_q.s7_res),
        .ridx_a_i  (st_q.s3_rd),
        .ridx_b_i  (st_q.s3_rs),
        .rdata_a_o (rf_a),
        .rdata_b_o (rf_b),
        .flat_o    (regs_o)
    );

    rrseq_arith #(
        .XLEN (XLEN)
    ) u_arith (
        .a_i   (st_q.s5_a),
        .b_i   (st_q.s5_b),
        .sub_i (st_q.s5_kind == K_SUB),
        .y_o   (arith_y)
    );

    rrseq_logic #(
        .XLEN (XLEN)
    ) u_logic (
        .a_i   (st_q.s5_a),
        .b_i   (st_q.s5_b),
        .sel_i (lsel_of(st_q.s5_kind)),
        .y_o   (logic_y)
    );

    always_comb begin
        st_d = st_q;

        // issue control: one fetch per four cycles
        st_d.phase = st_q.phase + 2'd1;
        if (fetch) begin
            st_d.pc = st_q.pc + AW'(1);
        end
        st_d.s2_v = fetch;

        // decode: RAM word is valid one cycle after the fetch
        st_d.s3_v    = st_q.s2_v;
        st_d.s3_kind = decode_kind(iword[OP_HI:OP_LO]);
        st_d.s3_rd   = iword[RD_HI:RD_LO];
        st_d.s3_rs   = iword[RS_HI:RS_LO];

        // register read, with compare against the writeback step
        st_d.s4_v      = st_q.s3_v;
        st_d.s4_kind   = st_q.s3_kind;
        st_d.s4_rd     = st_q.s3_rd;
        st_d.s4_rdv    = rf_a;
        st_d.s4_rsv    = rf_b;
        st_d.s4_hit_rd = wb_we && (st_q.s7_rd == st_q.s3_rd);
        st_d.s4_hit_rs = wb_we && (st_q.s7_rd == st_q.s3_rs);
        st_d.s4_fwd    = st_q.s7_res;

        // operand select: forwarded value wins over register file
        st_d.s5_v    = st_q.s4_v;
        st_d.s5_kind = st_q.s4_kind;
        st_d.s5_rd   = st_q.s4_rd;
        st_d.s5_a    = st_q.s4_hit_rd ? st_q.s4_fwd : st_q.s4_rdv;
        st_d.s5_b    = st_q.s4_hit_rs ? st_q.s4_fwd : st_q.s4_rsv;

        // execute: every unit works, each result is registered
        st_d.s6_v     = st_q.s5_v;
        st_d.s6_we    = (st_q.s5_kind != K_NOP);
        st_d.s6_unit  = unit_of(st_q.s5_kind);
        st_d.s6_rd    = st_q.s5_rd;
        st_d.s6_arith = arith_y;
        st_d.s6_logic = logic_y;
        st_d.s6_move  = st_q.s5_b;

        // result select
        st_d.s7_v  = st_q.s6_v;
        st_d.s7_we = st_q.s6_we;
        st_d.s7_rd = st_q.s6_rd;
        case (st_q.s6_unit)
            U_ARITH: st_d.s7_res = st_q.s6_arith;
            U_LOGIC: st_d.s7_res = st_q.s6_logic;
            default: st_d.s7_res = st_q.s6_move;
        endcase

        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign fetch_o      = fetch & ~rst_i;
    assign fetch_pc_o   = st_q.pc;
    assign retire_o     = st_q.s7_v;
    assign retire_we_o  = wb_we;
    assign retire_rd_o  = st_q.s7_rd;
    assign retire_val_o = st_q.s7_res;

endmodule

// File: rtl/rrseq_core_chk.sv
`timescale 1ns/1ps
module rrseq_core_chk #(
    parameter int XLEN = 32,
    parameter int NREG = 8,
    parameter int AW   = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 fetch_o,
    input logic [AW-1:0]        fetch_pc_o,
    input logic                 retire_o,
    input logic                 retire_we_o,
    input logic [RIDX-1:0]      retire_rd_o,
    input logic [XLEN-1:0]      retire_val_o,
    input logic [NREG*XLEN-1:0] regs_o
);

    logic [NREG-1:0][XLEN-1:0] view;
    logic [2:0]    gap_q;
    logic          seen_q;
    logic [AW-1:0] last_pc_q;

    assign view = regs_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            last_pc_q <= '0;
        end else if (fetch_o) begin
            gap_q     <= '0;
            seen_q    <= 1'b1;
            last_pc_q <= fetch_pc_o;
        end else if (gap_q != 3'd7) begin
            gap_q <= gap_q + 3'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        rst_i |=> !retire_o);

    p_fetch_gap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_o && seen_q |-> gap_q == 3'd3);

    p_fetch_pc_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_o && seen_q |-> fetch_pc_o == last_pc_q + AW'(1));

    p_retire_lat_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_o |-> $past(fetch_o, 6));

    p_retire_gap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_o |=> !retire_o);

    p_nop_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_o && !retire_we_o |=> $stable(regs_o));

    p_wb_value_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_o && retire_we_o |=> view[$past(retire_rd_o)] == $past(retire_val_o));

endmodule

bind rrseq_core rrseq_core_chk #(
    .XLEN (XLEN),
    .NREG (NREG),
    .AW   (AW)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .fetch_o      (fetch_o),
    .fetch_pc_o   (fetch_pc_o),
    .retire_o     (retire_o),
    .retire_we_o  (retire_we_o),
    .retire_rd_o  (retire_rd_o),
    .retire_val_o (retire_val_o),
    .regs_o       (regs_o)
);

// File: tb/rrseq_core_tb.sv
`timescale 1ns/1ps
module rrseq_core_tb;

    localparam int XLEN = 32;
    localparam int NREG = 8;
    localparam int NRUN = 260;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic        fetch_o;
    logic [7:0]  fetch_pc_o;
    logic        retire_o;
    logic        retire_we_o;
    logic [2:0]  retire_rd_o;
    logic [31:0] retire_val_o;
    logic [255:0] regs_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] prog [256];
    logic [31:0] model [8];
    int stamp [NRUN + 8];

    always #2.5 clk = ~clk;

    rrseq_core u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .imem_we_i    (we),
        .imem_waddr_i (waddr),
        .imem_wdata_i (wdata),
        .fetch_o      (fetch_o),
        .fetch_pc_o   (fetch_pc_o),
        .retire_o     (retire_o),
        .retire_we_o  (retire_we_o),
        .retire_rd_o  (retire_rd_o),
        .retire_val_o (retire_val_o),
        .regs_o       (regs_o)
    );

    function automatic logic [31:0] seed(int k);
        return 32'h1111_1111 * 32'(k + 1);
    endfunction

    function automatic logic [31:0] ref_op(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return b;
            default: return a;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_prog(string tag);
        int cyc;
        int nf;
        int nr;
        int last_f;
        int last_r;
        // load while in reset
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            we = 1'b1;
            waddr = 8'(i);
            wdata = prog[i];
        end
        @(negedge clk);
        we = 1'b0;
        // reset state, R1
        for (int k = 0; k < NREG; k++) begin
            model[k] = seed(k);
            check("R1", "reset reg", regs_o[k*32 +: 32], seed(k));
        end
        check("R1", "retire in reset", 32'(retire_o), 32'd0);
        check("R1", "fetch in reset", 32'(fetch_o), 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        cyc = 0; nf = 0; nr = 0; last_f = 0; last_r = 0;
        while (nr < NRUN) begin
            @(negedge clk);
            for (int k = 0; k < NREG; k++) begin
                check({tag, " R6 R7"}, $sformatf("reg%0d", k), regs_o[k*32 +: 32], model[k]);
            end
            if (fetch_o) begin
                if (nf == 0) begin
                    check("R1", "first fetch cycle", 32'(cyc), 32'd0);
                end else begin
                    check("R5", "fetch spacing", 32'(cyc - last_f), 32'd4);
                end
                check("R5", "fetch pc", 32'(fetch_pc_o), 32'(nf % 256));
                if (nf < NRUN + 8) stamp[nf] = cyc;
                last_f = cyc;
                nf++;
            end
            if (retire_o) begin
                logic [15:0] w;
                int op;
                int rd;
                int rs;
                logic [31:0] res;
                w = prog[nr % 256];
                op = int'(w[15:12]);
                rd = int'(w[11:9]);
                rs = int'(w[2:0]);
                res = ref_op(op, model[rd], model[rs]);
                check("R6", "retire latency", 32'(cyc), 32'(stamp[nr] + 6));
                if (nr > 0) check("R6", "retire spacing", 32'(cyc - last_r), 32'd4);
                check({tag, " R4"}, "write flag", 32'(retire_we_o), (op < 6) ? 32'd1 : 32'd0);
                if (op < 6) begin
                    check("R8", "retire rd", 32'(retire_rd_o), 32'(rd));
                    check({tag, " R2 R8"}, "retire value", retire_val_o, res);
                    model[rd] = res;
                end
                last_r = cyc;
                nr++;
            end
            cyc++;
        end
    endtask

    initial begin
        // full sweep of opcode x rd x rs over four loads; bits [8:3] filled (R3)
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 256; n++) begin
                int idx;
                logic [5:0] mid;
                idx = s * 256 + n;
                mid = 6'(idx * 37) ^ 6'h2A;
                prog[n] = {4'(idx >> 6), 3'(idx >> 3), mid, 3'(idx)};
            end
            run_prog("R2 R3 R9 sweep");
        end
        // chain: source is always the previous destination (R7)
        for (int n = 0; n < 256; n++) begin
            prog[n] = {4'(n % 6), 3'(n * 3), 6'd0, 3'((n + 7) * 3)};
        end
        run_prog("R7 chain");
        // mostly undefined opcodes interleaved with writes to one register (R4)
        for (int n = 0; n < 256; n++) begin
            if (n % 3 == 0) prog[n] = {4'(n % 6), 3'd2, 6'd0, 3'd2};
            else            prog[n] = {4'(6 + n % 10), 3'd2, 6'h3F, 3'(n)};
        end
        run_prog("R4 nop");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule